// File: doc/BRIEF.md
# Floating-Point Immediate Load and Insert Unit

This block is the execute datapath for two operations that fill a 64-bit floating-point register from 16-bit immediates, with no memory access. The load operation treats the immediate as a bfloat16 value. It places the immediate in the upper half of a 32-bit binary float, clears the lower half, and widens the result to the 64-bit format. The insert operation takes the current 64-bit register value and narrows it to single format. It overwrites the low 16 bits of that single value with the immediate, widens the result again, and returns it for writing to the same register.

Used in that order, the two operations build any 32-bit float constant, denormals included, in two instructions. Narrowing works by bit selection and never rounds. Widening renormalises single denormals into the 64-bit format. No status flag or exception is ever produced. The result appears one clock after the operation is presented, together with a write enable. The parameter `OUT_REG = 0` makes the path purely combinational.

Top module: `fp_imm_unit`

## Requirements
- R1: Load (opSel = 0) forms the single value {imm, 16'h0000} and writes that value widened to 64 bits; e.g. imm 0x3F80 gives 0x3FF0000000000000.
- R2: Load with imm 0x0000 writes exactly 0x0000000000000000 (+0.0), whatever regRd holds; imm 0x8000 writes 0x8000000000000000.
- R3: Insert (opSel = 1) narrows regRd to single format, replaces single bits 15:0 with imm, and writes the widened result. Narrowing by bit selection applies when the 64-bit biased exponent E is above 896, or is 0: it keeps sign, E[10], E[6:0] and fraction bits 51:29.
- R4: When 874 <= E <= 896, narrowing yields a single denormal whose fraction is {1, regRd[51:29]} shifted right by 897 - E, truncated with no rounding.
- R5: Widening a normal single (exponent 1..254) keeps the sign, adds 896 to the exponent and appends 29 zero fraction bits.
- R6: Widening a single denormal normalises it: with z leading zeros in the 23-bit fraction, the exponent is 896 - z. The fraction is the original one shifted left by z + 1, keeping 23 bits and zero-extended. A single zero widens to a zero of the same sign.
- R7: Single exponent 0xFF widens to exponent 0x7FF with the fraction zero-extended, so infinities, quiet NaNs and signalling NaNs keep their payload bits and their kind.
- R8: A regRd whose exponent is outside single range is narrowed by bit selection (R3) even when that changes its value. Examples are E = 2046, or E between 1 and 873. No flag or exception output exists or is produced.
- R9: wrEn is high exactly one cycle after a cycle with opValid high. When opValid is low, wrEn is low and wrData keeps its last value.
- R10: During and immediately after reset (rstN low, active-low), wrEn is 0 and wrData is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 1 | 0 = load immediate, 1 = insert low half |
| imm | input | 16 | Immediate operand |
| regRd | input | 64 | Current value of the target register (used by insert) |
| wrData | output | 64 | Value to write to the target register |
| wrEn | output | 1 | Write strobe for wrData |

## Verification
Nearly all of the state here is the output register, so a fault in the narrowing, splicing or widening logic shows on wrData one cycle after the operation that exercises it. That delay is fixed, and no later operation can hide or correct the error. A wrong leading-zero count or wrong denormal shift only shows for denormal patterns. For that reason the vectors include both ends of the denormal range, a truncating shift, and out-of-range exponents on the insert path. A write-enable fault shows in the same cycle as the data it should qualify, and the idle and reset checks catch it.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
  localparam int SGL_W    = 32;
  localparam int SGL_EXP  = 8;
  localparam int SGL_FRAC = SGL_W - 1 - SGL_EXP;           // 23
  localparam int DBL_W    = 64;
  localparam int DBL_EXP  = 11;
  localparam int DBL_FRAC = DBL_W - 1 - DBL_EXP;           // 52
  localparam int FRAC_PAD = DBL_FRAC - SGL_FRAC;           // 29
  localparam int IMM_W    = SGL_W / 2;                     // 16
  localparam int LZC_W    = $clog2(SGL_FRAC + 1);          // 5
  localparam int REBIAS   = (1 << (DBL_EXP - 1)) - (1 << (SGL_EXP - 1)); // 896
  localparam int DEN_LO   = REBIAS - SGL_FRAC + 1;         // 874

  typedef struct packed {
    logic wr;      // an operation is to be executed
    logic insert;  // splice path instead of plain load
  } fpimm_ctrl_t;
endpackage

// File: rtl/fpimm_ctrl.sv
module fpimm_ctrl
  import fpimm_pkg::*;
(
  input  logic        opValid,
  input  logic        opSel,
  output fpimm_ctrl_t ctrl
);
  always_comb begin
    ctrl.wr     = opValid;
    ctrl.insert = opValid & opSel;
  end
endmodule

// File: rtl/fpimm_datapath.sv
module fpimm_datapath
  import fpimm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  fpimm_ctrl_t        ctrl,
  input  logic [IMM_W-1:0]   imm,
  input  logic [DBL_W-1:0]   regRd,
  output logic [DBL_W-1:0]   wrData,
  output logic               wrEn
);
  // ---------------- narrow 64 -> 32 (no rounding, no flags) -------------
  logic [DBL_EXP-1:0]  dExp;
  logic                inDen;
  logic [LZC_W-1:0]    denShift;
  logic [SGL_FRAC:0]   denMant;
  logic [SGL_W-1:0]    narrowed;

  always_comb begin
    dExp     = regRd[DBL_W-2 -: DBL_EXP];
    inDen    = (dExp >= DBL_EXP'(DEN_LO)) && (dExp <= DBL_EXP'(REBIAS));
    denShift = LZC_W'(DBL_EXP'(REBIAS + 1) - dExp);
    denMant  = {1'b1, regRd[DBL_FRAC-1 -: SGL_FRAC]} >> denShift;
    if (inDen)
      narrowed = {regRd[DBL_W-1], {SGL_EXP{1'b0}}, denMant[SGL_FRAC-1:0]};
    else
      narrowed = {regRd[DBL_W-1], dExp[DBL_EXP-1], dExp[SGL_EXP-2:0],
                  regRd[DBL_FRAC-1 -: SGL_FRAC]};
  end

  // ---------------- splice / load select -------------------------------
  logic [SGL_W-1:0] single;
  always_comb begin
    if (ctrl.insert) single = {narrowed[SGL_W-1:IMM_W], imm};
    else             single = {imm, {IMM_W{1'b0}}};
  end

  // ---------------- widen 32 -> 64 (denormals normalised) -------------
  logic [SGL_EXP-1:0]  sExp;
  logic [SGL_FRAC-1:0] sFrac;
  logic [LZC_W-1:0]    lzc;
  logic                seen;
  logic [SGL_FRAC-1:0] normFrac;
  logic [DBL_EXP-1:0]  wExp;
  logic [SGL_FRAC-1:0] wFrac;
  logic [DBL_W-1:0]    widened;

  always_comb begin
    sExp  = single[SGL_W-2 -: SGL_EXP];
    sFrac = single[SGL_FRAC-1:0];
    lzc   = '0;
    seen  = 1'b0;
    for (int i = SGL_FRAC - 1; i >= 0; i--) begin
      if (!seen && sFrac[i]) begin
        lzc  = LZC_W'(SGL_FRAC - 1 - i);
        seen = 1'b1;
      end
    end
    normFrac = sFrac << (lzc + LZC_W'(1));
    if (sExp == '1) begin
      wExp  = '1;
      wFrac = sFrac;
    end else if (sExp != '0) begin
      wExp  = DBL_EXP'(sExp) + DBL_EXP'(REBIAS);
      wFrac = sFrac;
    end else if (sFrac == '0) begin
      wExp  = '0;
      wFrac = '0;
    end else begin
      wExp  = DBL_EXP'(REBIAS) - DBL_EXP'(lzc);
      wFrac = normFrac;
    end
    widened = {single[SGL_W-1], wExp, wFrac, {FRAC_PAD{1'b0}}};
  end

  // ---------------- output stage --------------------------------------
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wrData <= '0;
          wrEn   <= 1'b0;
        end else begin
          wrEn <= ctrl.wr;
          if (ctrl.wr) wrData <= widened;
        end
      end

      a_r9_wren_follows_valid: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.wr |=> wrEn);
      a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.wr |=> (!wrEn && $stable(wrData)));
      a_r2_zero_load: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.wr && !ctrl.insert && imm == '0) |=> (wrData == '0));
    end else begin : g_comb
      assign wrData = widened;
      assign wrEn   = ctrl.wr;
    end
  endgenerate

  // datapath invariants between narrowing/widening stages
  a_r7_special_exp: assert property (@(posedge clk) disable iff (!rstN)
    (sExp == '1) |-> (widened[DBL_W-2 -: DBL_EXP] == '1));
  a_r6_denorm_range: assert property (@(posedge clk) disable iff (!rstN)
    (sExp == '0 && sFrac != '0) |->
      (widened[DBL_W-2 -: DBL_EXP] >= DBL_EXP'(DEN_LO) &&
       widened[DBL_W-2 -: DBL_EXP] <= DBL_EXP'(REBIAS)));
  a_r4_den_narrow_zero_exp: assert property (@(posedge clk) disable iff (!rstN)
    inDen |-> (narrowed[SGL_W-2 -: SGL_EXP] == '0 && narrowed[SGL_FRAC-1:0] != '0));
endmodule

// File: rtl/fp_imm_unit.sv
module fp_imm_unit
  import fpimm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic        opSel,
  input  logic [15:0] imm,
  input  logic [63:0] regRd,
  output logic [63:0] wrData,
  output logic        wrEn
);
  fpimm_ctrl_t ctrl;

  fpimm_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .ctrl    (ctrl)
  );

  fpimm_datapath #(.OUT_REG(OUT_REG)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .imm    (imm),
    .regRd  (regRd),
    .wrData (wrData),
    .wrEn   (wrEn)
  );
endmodule

// File: tb/fp_imm_unit_tb.sv
module fp_imm_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opSel = 1'b0;
  logic [15:0] imm = '0;
  logic [63:0] regRd = '0;
  logic [63:0] wrData;
  logic        wrEn;

  int nRun = 0;
  int nFail = 0;

  fp_imm_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .imm(imm), .regRd(regRd), .wrData(wrData), .wrEn(wrEn)
  );

  always #5 clk = ~clk;

  localparam int NV = 17;
  // op: 0 load, 1 insert
  localparam logic        V_OP  [NV] = '{0,0,0,0,0,0,0,0,0,0, 1,1,1,1,1,1,1};
  localparam logic [15:0] V_IMM [NV] = '{
    16'h3F80, 16'h0000, 16'h8000, 16'h7F80, 16'hFF80, 16'h7FC0, 16'h7F81,
    16'h4049, 16'h0040, 16'h8001,
    16'h0001, 16'h0001, 16'hFFFF, 16'h1234, 16'h0000, 16'hABCD, 16'h1111};
  localparam logic [63:0] V_REG [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
    64'h0, 64'h0, 64'h0,
    64'h3FF0_0000_0000_0000, 64'h0, 64'h380F_C000_0000_0000,
    64'h7FE0_0000_0000_0000, 64'hB690_0000_0000_0000,
    64'h7FF8_0000_0000_0001, 64'h37FF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h3FF0_0000_0000_0000,  // R1 1.0
    64'h0000_0000_0000_0000,  // R2 +0 despite register contents
    64'h8000_0000_0000_0000,  // R2 -0
    64'h7FF0_0000_0000_0000,  // R7 +inf
    64'hFFF0_0000_0000_0000,  // R7 -inf
    64'h7FF8_0000_0000_0000,  // R7 quiet NaN
    64'h7FF0_2000_0000_0000,  // R7 signalling NaN
    64'h4009_2000_0000_0000,  // R5 3.140625
    64'h3800_0000_0000_0000,  // R6 largest-exponent denormal 2^-127
    64'hB7A0_0000_0000_0000,  // R6 negative denormal
    64'h3FF0_0000_2000_0000,  // R3 insert into 1.0
    64'h36A0_0000_0000_0000,  // R6 smallest denormal
    64'h380F_FFFF_C000_0000,  // R4 largest denormal
    64'h47E0_0246_8000_0000,  // R8 exponent above single range
    64'hBE90_0000_0000_0000,  // R8 exponent below denormal range
    64'h7FF8_1579_A000_0000,  // R7 insert into NaN
    64'h37FF_8888_8000_0000}; // R4 truncating denormal shift
  localparam int V_REQ [NV] = '{1,2,2,7,7,7,7,5,6,6,3,6,4,8,8,7,4};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  // drive at negedge, registered at next posedge, sample at following negedge
  task automatic runOp(input logic op, input logic [15:0] iv, input logic [63:0] rv);
    @(negedge clk);
    opValid = 1'b1; opSel = op; imm = iv; regRd = rv;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 wrEn in reset", {63'b0, wrEn}, 64'h0);
    check("R10 wrData in reset", wrData, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 wrEn after reset", {63'b0, wrEn}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      runOp(V_OP[k], V_IMM[k], V_REG[k]);
      check($sformatf("R%0d vector %0d data", V_REQ[k], k), wrData, V_EXP[k]);
      check($sformatf("R9 vector %0d wrEn", k), {63'b0, wrEn}, 64'h1);
    end

    // R9: idle cycle drops wrEn and holds data, even with other inputs moving
    @(negedge clk);
    opSel = 1'b0; imm = 16'h3F80; regRd = 64'h1234;
    check("R9 idle wrEn", {63'b0, wrEn}, 64'h0);
    check("R9 idle hold", wrData, V_EXP[NV-1]);
    @(negedge clk);
    check("R9 idle hold 2", wrData, V_EXP[NV-1]);

    // R4: round trip through denormal narrowing with immediate zero
    runOp(1'b1, 16'h0000, 64'h3800_0000_0000_0000);
    check("R4 roundtrip 2^-127", wrData, 64'h3800_0000_0000_0000);

    // back-to-back operations: R1 then R3
    @(negedge clk);
    opValid = 1'b1; opSel = 1'b0; imm = 16'hC000; regRd = '0;
    @(negedge clk);
    check("R1 back-to-back load -2.0", wrData, 64'hC000_0000_0000_0000);
    opSel = 1'b1; imm = 16'h0000; regRd = 64'hC000_0000_0000_0000;
    @(negedge clk);
    opValid = 1'b0;
    check("R3 back-to-back insert", wrData, 64'hC000_0000_0000_0000);
    check("R9 back-to-back wrEn", {63'b0, wrEn}, 64'h1);

    // R10: reset in the middle of operation clears outputs
    @(negedge clk);
    opValid = 1'b1; rstN = 1'b0;
    @(negedge clk);
    check("R10 mid-run wrEn", {63'b0, wrEn}, 64'h0);
    check("R10 mid-run wrData", wrData, 64'h0);
    opValid = 1'b0; rstN = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule